// File: doc/BRIEF.md
# Windowed Watchdog with Early Warning

This block supervises software by requiring a refresh that is neither late nor early. A 7-bit counter steps down by one on every tick. A tick comes every 2^(DIV_LOG2 + sel) clock cycles: DIV_LOG2 = 12 gives the fixed divide-by-4096, and the 2-bit select adds a power of two from 1 to 8. Software refreshes the watchdog by writing a new counter value. The write must come while the counter is at or below the programmed window value. If it comes while the counter is still above the window, the watchdog trips. If no refresh comes before the counter steps from 0x40 to 0x3F, the watchdog also trips. A trip gives a one-cycle reset pulse, and the block then returns to its reset state.

A sticky early-warning flag sets when the counter decrements to 0x40. The flag gives one last chance to refresh, or to save state, before the timeout. It drives the interrupt line when the warning enable is set.

The control state machine has three states. WD_IDLE: disabled, the counter still runs. WD_ARMED: enabled, trips are live. WD_FIRE: the reset pulse cycle. The transitions are:
- arm, WD_IDLE to WD_ARMED: a counter write with the enable bit set.
- trip, WD_ARMED to WD_FIRE: a timeout or an early refresh.
- recover, WD_FIRE to WD_IDLE: always, after one cycle.

Only a trip or the reset input leaves WD_ARMED.

Top module: `window_watchdog`

## Requirements
- R1: After the reset input:
  - the counter reads 0x7F and the window reads 0x7F;
  - prescaler select and warning enable are 0;
  - the flag is clear and the watchdog is disabled;
  - irq and wdg_rst are low.
- R2: The counter decrements by one every 2^(DIV_LOG2+sel) clock cycles, wrapping from 0x00 to 0x7F. It does so whether or not the watchdog is enabled.
- R3: A write to address 0 loads data bits [6:0] into the counter. Data bit 7 set enables the watchdog. A write with bit 7 clear never disables it. Address 0 reads {enable, counter}.
- R4: While enabled, the counter stepping from 0x40 to 0x3F with no counter write in that cycle gives a reset pulse.
- R5: While enabled:
  - a counter write while the counter is above the window value gives a reset pulse;
  - a counter write at or below the window value reloads the counter with no pulse.
- R6: While disabled, no reset pulse is produced. This holds for the 0x40 to 0x3F step and for any counter write.
- R7: The flag (address 3, bit 0) sets when the counter decrements from 0x41 to 0x40. It stays set until a write to address 3 with bit 0 set. A set in the same cycle wins over the clear.
- R8: irq equals the flag AND the warning enable (address 2, bit 2).
- R9: wdg_rst is high for exactly the one cycle after the trip edge. On that edge all registers return to their R1 values. Writes sampled during the pulse cycle are ignored.
- R10: Address 1 holds the window in bits [6:0]. Address 2 holds the prescaler select in bits [1:0] and the warning enable in bit 2. Reads return these fields with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CNT_W+1 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W+1 | Read data, combinational |
| irq | output | 1 | Early-warning interrupt |
| wdg_rst | output | 1 | One-cycle reset pulse |

## Verification
The bench builds the block with DIV_LOG2 = 2 and leaves the counter width and select width at their defaults. A tick then comes every 4 to 32 cycles. This makes a full descent from 0x7F through 0x40 take a few hundred cycles. It brings timeouts, wrap-around and the flag set within reach many times in one run. The window and prescaler logic are unchanged by this setting, so early refreshes, valid refreshes and prescaler changes are exercised exactly as at the default divide.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

    typedef logic [1:0] wwd_addr_t;

    localparam wwd_addr_t A_COUNT  = 2'd0;
    localparam wwd_addr_t A_WINDOW = 2'd1;
    localparam wwd_addr_t A_CONFIG = 2'd2;
    localparam wwd_addr_t A_STATUS = 2'd3;
endpackage

// File: rtl/wwd_tick_gen.sv
module wwd_tick_gen #(
    parameter int DIV_LOG2 = 12,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NSEL = 1 << SEL_W;
    localparam int DCW  = DIV_LOG2 + NSEL - 1;

    logic [DCW-1:0] div_q;
    logic [DCW-1:0] lim_tab [NSEL];

    // One terminal count per select value: 2^(DIV_LOG2+g) - 1
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_tab[g] = {DCW{1'b1}} >> (NSEL - 1 - g);
    end

    // ">=" so that lowering the select mid-period still ticks promptly
    assign tick = !hold && (div_q >= lim_tab[sel]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (clear)
            div_q <= '0;
        else if (!hold)
            div_q <= tick ? '0 : div_q + DCW'(1);
    end

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
    import wwd_pkg::*;
#(
    parameter int CW    = 7,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             frozen,
    input  logic             tick,
    input  logic             wr_en,
    input  wwd_addr_t        wr_addr,
    input  logic [CW:0]      wr_data,
    input  wwd_addr_t        rd_addr,
    output logic [SEL_W-1:0] sel,
    output logic             ewi,
    output logic             flag,
    output logic             cause,
    output logic             arm_req,
    output logic [CW:0]      rd_data
);
    localparam int DW = CW + 1;
    localparam logic [CW-1:0] CNT_TOP  = '1;
    localparam logic [CW-1:0] CNT_WARN = CW'(1) << (CW - 1);

    logic [CW-1:0]    cnt_q, win_q;
    logic [SEL_W-1:0] sel_q;
    logic             ewi_q, flag_q;
    logic             wr_ok, wr_cnt, flag_set, flag_clr;

    assign wr_ok    = wr_en && !frozen;
    assign wr_cnt   = wr_ok && (wr_addr == A_COUNT);
    assign flag_set = tick && !wr_cnt && (cnt_q == CNT_WARN + CW'(1));
    assign flag_clr = wr_ok && (wr_addr == A_STATUS) && wr_data[0];
    assign arm_req  = wr_cnt && wr_data[CW];
    assign cause    = armed && ((wr_cnt && (cnt_q > win_q)) ||
                                (tick && !wr_cnt && (cnt_q == CNT_WARN)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || cause) begin
            cnt_q  <= CNT_TOP;
            win_q  <= CNT_TOP;
            sel_q  <= '0;
            ewi_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_cnt)
                cnt_q <= wr_data[CW-1:0];
            else if (tick)
                cnt_q <= cnt_q - CW'(1);
            if (wr_ok && wr_addr == A_WINDOW)
                win_q <= wr_data[CW-1:0];
            if (wr_ok && wr_addr == A_CONFIG) begin
                sel_q <= wr_data[SEL_W-1:0];
                ewi_q <= wr_data[SEL_W];
            end
            if (flag_set)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    assign sel  = sel_q;
    assign ewi  = ewi_q;
    assign flag = flag_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_COUNT:  rd_data = {armed, cnt_q};
            A_WINDOW: rd_data = {1'b0, win_q};
            A_CONFIG: begin
                rd_data[SEL_W-1:0] = sel_q;
                rd_data[SEL_W]     = ewi_q;
            end
            A_STATUS: rd_data = DW'(flag_q);
            default:  rd_data = '0;
        endcase
    end

    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_cnt) && !$past(cause) && cnt_q != $past(cnt_q))
            |-> cnt_q == $past(cnt_q) - CW'(1));
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_q) && !$past(flag_clr) && !$past(cause)) |-> flag_q);
    assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cause) |-> (cnt_q == CNT_TOP && win_q == CNT_TOP && !flag_q && !ewi_q));
endmodule

// File: rtl/wwd_fsm.sv
module wwd_fsm
    import wwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic cause,
    output logic armed,
    output logic firing
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WD_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:  if (arm_req) state_d = WD_ARMED;   // arm
            WD_ARMED: if (cause)   state_d = WD_FIRE;    // trip
            WD_FIRE:               state_d = WD_IDLE;    // recover
            default:               state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        armed  = (state_q == WD_ARMED);
        firing = (state_q == WD_FIRE);
    end

    assert_pulse_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        firing |=> !firing);
    assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !cause) |=> armed);
    assert_quiet_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !firing);
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wwd_pkg::*;
#(
    parameter int DIV_LOG2 = 12,
    parameter int CNT_W    = 7,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W:0]   wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W:0]   rd_data,
    output logic             irq,
    output logic             wdg_rst
);
    logic             tick, armed, firing, cause, arm_req, ewi, flag;
    logic [SEL_W-1:0] sel;

    wwd_tick_gen #(.DIV_LOG2(DIV_LOG2), .SEL_W(SEL_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .hold(firing), .clear(cause),
        .sel(sel), .tick(tick)
    );

    wwd_regs #(.CW(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .armed(armed), .frozen(firing), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .sel(sel), .ewi(ewi), .flag(flag), .cause(cause), .arm_req(arm_req),
        .rd_data(rd_data)
    );

    wwd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .cause(cause),
        .armed(armed), .firing(firing)
    );

    assign irq     = flag && ewi;
    assign wdg_rst = firing;

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_addr != A_STATUS || rd_data[0]));
endmodule

// File: tb/window_watchdog_test.sv
module window_watchdog_test;
    localparam int DIVL = 2;

    logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq, wdg_rst;

    always #5 clk = ~clk;

    window_watchdog #(.DIV_LOG2(DIVL), .CNT_W(7), .SEL_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .wdg_rst(wdg_rst)
    );

    int n_cmp = 0, n_bad = 0, n_pulse = 0;
    bit rot_on = 0, done = 0;
    int m_cnt, m_win, m_psc, m_ewi, m_flag, m_en, m_fire, m_div;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 127; m_win = 127; m_psc = 0; m_ewi = 0;
        m_flag = 0; m_en = 0; m_div = 0;
    endtask

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset(); m_fire = 0;
        end else if (m_fire != 0) begin
            m_fire = 0;
        end else begin
            int  lim;
            bit  tk, w0, trip;
            lim  = (1 << (DIVL + m_psc)) - 1;
            tk   = (m_div >= lim);
            w0   = wr_en && wr_addr == 2'd0;
            trip = (m_en != 0) && ((w0 && m_cnt > m_win) || (tk && !w0 && m_cnt == 64));
            if (trip) begin
                model_reset(); m_fire = 1;
            end else begin
                m_div = tk ? 0 : m_div + 1;
                if (tk && !w0 && m_cnt == 65) m_flag = 1;
                else if (wr_en && wr_addr == 2'd3 && wr_data[0]) m_flag = 0;
                if (w0) begin
                    m_cnt = int'(wr_data[6:0]);
                    if (wr_data[7]) m_en = 1;
                end else if (tk) m_cnt = (m_cnt + 127) % 128;
                if (wr_en && wr_addr == 2'd1) m_win = int'(wr_data[6:0]);
                if (wr_en && wr_addr == 2'd2) begin
                    m_psc = int'(wr_data[1:0]); m_ewi = int'(wr_data[2]);
                end
            end
        end
    end

    // Read address walks through all registers once enabled
    always @(posedge clk) begin
        #3;
        if (rot_on) rd_addr <= rd_addr + 2'd1;
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && rot_on && !done) begin
            int exp;
            string tag;
            case (rd_addr)
                2'd0: begin exp = (m_en << 7) | m_cnt; tag = "R2 R3 counter/enable"; end
                2'd1: begin exp = m_win; tag = "R10 window"; end
                2'd2: begin exp = (m_ewi << 2) | m_psc; tag = "R10 config"; end
                default: begin exp = m_flag; tag = "R7 flag"; end
            endcase
            check(int'(rd_data) == exp, tag, int'(rd_data), exp);
            check(irq == ((m_flag & m_ewi) != 0), "R8 irq", int'(irq), m_flag & m_ewi);
            check(wdg_rst == (m_fire != 0), "R4 R5 R6 R9 pulse", int'(wdg_rst), m_fire);
            if (wdg_rst) n_pulse++;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #3;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #3;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        int p0;
        logic [7:0] rv [4];
        rv[0] = 8'h7F; rv[1] = 8'h7F; rv[2] = 8'h00; rv[3] = 8'h00;
        repeat (3) @(posedge clk);
        // R1: reset values seen while reset is held
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1;
            check(rd_data == rv[a], "R1 reset register", int'(rd_data), int'(rv[a]));
        end
        check(irq == 1'b0 && wdg_rst == 1'b0, "R1 outputs low", int'({irq, wdg_rst}), 0);
        rd_addr = 2'd0;
        @(negedge clk); #1;
        rst_n = 1'b1;
        rot_on = 1;

        // Disabled descent: flag, irq, no pulse
        wr(2'd2, 8'h04);
        p0 = n_pulse;
        idle(300);
        check(irq == 1'b1, "R8 irq after warning", int'(irq), 1);
        check(n_pulse == p0, "R6 no pulse while disabled", n_pulse - p0, 0);
        wr(2'd3, 8'h01);
        check(irq == 1'b0, "R7 flag cleared", int'(irq), 0);
        wr(2'd1, 8'h30);
        wr(2'd0, 8'h7F);
        idle(4);
        check(n_pulse == p0, "R6 write while disabled", n_pulse - p0, 0);

        // Timeout at prescaler select 1
        wr(2'd2, 8'h05);
        p0 = n_pulse;
        wr(2'd0, 8'hD0);
        idle(200);
        check(n_pulse - p0 == 1, "R4 timeout pulse", n_pulse - p0, 1);

        // Early refresh, with a write placed in the pulse cycle
        wr(2'd1, 8'h50);
        wr(2'd0, 8'hFF);
        p0 = n_pulse;
        @(posedge clk); #3;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'hF0;
        @(posedge clk); #3;
        wr_addr = 2'd1; wr_data = 8'h22;
        @(posedge clk); #3;
        wr_en = 1'b0;
        idle(8);
        check(n_pulse - p0 == 1, "R5 early refresh pulse", n_pulse - p0, 1);
        check(n_pulse - p0 == 1, "R9 single pulse", n_pulse - p0, 1);

        // Valid refreshes inside the window, then let it expire
        wr(2'd1, 8'h60);
        wr(2'd0, 8'hE0);
        p0 = n_pulse;
        for (int k = 0; k < 10; k++) begin
            idle(20);
            wr(2'd0, 8'h60);
        end
        check(n_pulse == p0, "R5 R3 refresh in window", n_pulse - p0, 0);
        idle(200);
        check(n_pulse - p0 == 1, "R4 expiry after refresh stop", n_pulse - p0, 1);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R9 watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end
endmodule